// File: doc/BRIEF.md
# Reliable-Bit Flip Search Unit

This block sits after the parity-check diagonalization stage of an ordered soft decoder for a binary linear code. It receives a syndrome that has already been transformed by the same row operations as the matrix, and the matrix columns that belong to the reliable (non-unit) bit positions. A syndrome with small weight means the errors are confined to the least-reliable part, where the unit columns let the residual syndrome mark them directly. A heavy syndrome means at least one reliable bit is wrong, so the unit tries tentative flips of reliable bits and keeps the cheapest resulting error pattern.

Each search cycle tests one single-flip candidate (reliable index equal to the cycle number) and `PPC` pair candidates. Pairs come only from the fair-reliable subset, which the upstream sorter places at reliable indices 0 to `N_FAIR-1`. Pairs are taken in lexicographic order (i<j). A candidate costs the number of flipped reliable bits plus the weight of its residual syndrome. The no-flip pattern is the starting best. A candidate replaces the best only when it is strictly cheaper, so the earliest of equal-cost candidates wins. Once every candidate has been tested, the unit reports the winning flips, the residual syndrome and the cost.

The control is a three-state machine. `ST_IDLE` goes to `ST_SEARCH` on `start` (capture), which latches the syndrome and columns and loads the no-flip best. `ST_SEARCH` stays in `ST_SEARCH` (step) until its last cycle, then goes to `ST_DONE` (finish). `ST_DONE` always returns to `ST_IDLE` (release).

Top module: `flip_search_unit`

## Requirements
- R1: After reset, busy, done, both flip-valid flags, best_cost and resid are all 0.
- R2: A start pulse seen in idle latches syn_in and cols_in (column k occupies bits k*SYN_W and up) and makes busy 1 from the next cycle. The search begins from the no-flip candidate, whose cost is the weight of the syndrome.
- R3: Every reliable index 0..N_REL-1 is tried as a single flip, once. Its residual is the syndrome XOR that column, and its cost is 1 plus the residual weight. The index is reported in flip_a with flip_a_vld=1 and flip_b_vld=0.
- R4: Every pair i<j with both indices below N_FAIR is tried. Its residual is the syndrome XOR both columns, and its cost is 2 plus the residual weight. The pair is reported with flip_a=i, flip_b=j and both valid flags at 1.
- R5: Search cycle c tests the single flip c (when c<N_REL) first, then the pairs with lexicographic ranks c*PPC to c*PPC+PPC-1. A candidate replaces the best only when its cost is strictly lower, so the earliest of equal-cost candidates is kept.
- R6: busy stays 1 for exactly max(N_REL, ceil(N_FAIR*(N_FAIR-1)/2 / PPC)) cycles. done is then 1 for one cycle, and the unit returns to idle.
- R7: In the last pair cycle, the slots beyond the final pair are masked and never affect the result.
- R8: start, syn_in and cols_in are ignored while busy is 1. The running search completes on the latched values.
- R9: The result outputs stay unchanged after done until the next accepted start.
- R10: best_cost always equals the number of valid flip flags plus the weight of resid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a search (accepted only when idle) |
| syn_in | input | SYN_W | Diagonalized syndrome |
| cols_in | input | N_REL*SYN_W | Reliable-position columns, column k at bits k*SYN_W |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle end-of-search flag |
| best_cost | output | COST_W | Cost of the winning candidate |
| flip_a | output | IDX_W | First flipped reliable index |
| flip_a_vld | output | 1 | flip_a holds a flip |
| flip_b | output | IDX_W | Second flipped reliable index |
| flip_b_vld | output | 1 | flip_b holds a flip |
| resid | output | SYN_W | Residual syndrome of the winning candidate |

## Verification
The bench builds the unit with SYN_W=8, N_REL=10, N_FAIR=8 and PPC=6. This gives 28 pairs over five pair cycles, and a search of ten cycles that is dominated by the single flips. With these values the last pair cycle holds only four real pairs, so the masked slots are exercised. A hand-built column set places the unique winner at pair (6,7), the final rank, and another puts a single-flip winner at index 9, outside the fair subset. With duplicated columns, two equal-cost single flips test the rule that the earlier candidate is kept.

// File: rtl/flip_search_pkg.sv
package flip_search_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SEARCH = 2'd1,
        ST_DONE   = 2'd2
    } fsm_e;

    // lexicographic successor of pair (i,j) with i<j<nf
    function automatic int succ_i(input int i, input int j, input int nf);
        return (j + 1 < nf) ? i : i + 1;
    endfunction

    function automatic int succ_j(input int i, input int j, input int nf);
        return (j + 1 < nf) ? j + 1 : i + 2;
    endfunction

endpackage

// File: rtl/fs_pair_gen.sv
module fs_pair_gen #(
    parameter int N_FAIR = 8,
    parameter int PPC    = 6,
    parameter int IDX_W  = 4
) (
    input  logic [IDX_W-1:0] cur_i,
    input  logic [IDX_W-1:0] cur_j,
    output logic [IDX_W-1:0] slot_i [PPC],
    output logic [IDX_W-1:0] slot_j [PPC],
    output logic [IDX_W-1:0] nxt_i,
    output logic [IDX_W-1:0] nxt_j
);
    import flip_search_pkg::*;

    always_comb begin
        int a;
        int b;
        int t;
        a = int'(cur_i);
        b = int'(cur_j);
        for (int k = 0; k < PPC; k++) begin
            slot_i[k] = IDX_W'(a);
            slot_j[k] = IDX_W'(b);
            t = succ_i(a, b, N_FAIR);
            b = succ_j(a, b, N_FAIR);
            a = t;
        end
        nxt_i = IDX_W'(a);
        nxt_j = IDX_W'(b);
    end

endmodule

// File: rtl/fs_cand_eval.sv
module fs_cand_eval #(
    parameter int SYN_W  = 8,
    parameter int COST_W = 4
) (
    input  logic [SYN_W-1:0]  syn,
    input  logic [SYN_W-1:0]  col_a,
    input  logic [SYN_W-1:0]  col_b,
    input  logic              use_b,
    output logic [SYN_W-1:0]  res,
    output logic [COST_W-1:0] cost
);
    always_comb begin
        res  = syn ^ col_a ^ (use_b ? col_b : '0);
        cost = COST_W'(use_b ? 2 : 1) + COST_W'($countones(res));
    end

endmodule

// File: rtl/fs_best_pick.sv
module fs_best_pick #(
    parameter int NC     = 7,
    parameter int SYN_W  = 8,
    parameter int COST_W = 4,
    parameter int IDX_W  = 4
) (
    input  logic [COST_W-1:0] in_cost,
    input  logic [IDX_W-1:0]  in_a,
    input  logic              in_av,
    input  logic [IDX_W-1:0]  in_b,
    input  logic              in_bv,
    input  logic [SYN_W-1:0]  in_res,
    input  logic              c_vld  [NC],
    input  logic [COST_W-1:0] c_cost [NC],
    input  logic [IDX_W-1:0]  c_a    [NC],
    input  logic [IDX_W-1:0]  c_b    [NC],
    input  logic              c_bv   [NC],
    input  logic [SYN_W-1:0]  c_res  [NC],
    output logic [COST_W-1:0] out_cost,
    output logic [IDX_W-1:0]  out_a,
    output logic              out_av,
    output logic [IDX_W-1:0]  out_b,
    output logic              out_bv,
    output logic [SYN_W-1:0]  out_res
);
    // strict less-than in evaluation order keeps the earliest on ties
    always_comb begin
        out_cost = in_cost;
        out_a    = in_a;
        out_av   = in_av;
        out_b    = in_b;
        out_bv   = in_bv;
        out_res  = in_res;
        for (int k = 0; k < NC; k++) begin
            if (c_vld[k] && (c_cost[k] < out_cost)) begin
                out_cost = c_cost[k];
                out_a    = c_a[k];
                out_av   = 1'b1;
                out_b    = c_b[k];
                out_bv   = c_bv[k];
                out_res  = c_res[k];
            end
        end
    end

endmodule

// File: rtl/flip_search_unit.sv
module flip_search_unit #(
    parameter int SYN_W  = 8,
    parameter int N_REL  = 10,
    parameter int N_FAIR = 8,
    parameter int PPC    = 6,
    localparam int COST_W = $clog2(SYN_W + 3),
    localparam int IDX_W  = $clog2(N_REL + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [SYN_W-1:0]       syn_in,
    input  logic [N_REL*SYN_W-1:0] cols_in,
    output logic                   busy,
    output logic                   done,
    output logic [COST_W-1:0]      best_cost,
    output logic [IDX_W-1:0]       flip_a,
    output logic                   flip_a_vld,
    output logic [IDX_W-1:0]       flip_b,
    output logic                   flip_b_vld,
    output logic [SYN_W-1:0]       resid
);
    import flip_search_pkg::*;

    localparam int NPAIRS   = N_FAIR * (N_FAIR - 1) / 2;
    localparam int PAIR_CYC = (NPAIRS + PPC - 1) / PPC;
    localparam int NCYC     = (N_REL > PAIR_CYC) ? N_REL : PAIR_CYC;
    localparam int CYC_W    = $clog2(NCYC + 1);
    localparam int NC       = PPC + 1;

    fsm_e state_q, state_n;

    logic [CYC_W-1:0] cyc_q;
    logic [SYN_W-1:0] syn_q;
    logic [SYN_W-1:0] cols_q [N_REL];
    logic [IDX_W-1:0] pi_q, pj_q, pi_n, pj_n;
    logic             last_cyc;

    logic [IDX_W-1:0] slot_i [PPC];
    logic [IDX_W-1:0] slot_j [PPC];

    logic              c_vld  [NC];
    logic [IDX_W-1:0]  c_a    [NC];
    logic [IDX_W-1:0]  c_b    [NC];
    logic              c_bv   [NC];
    logic [SYN_W-1:0]  c_cola [NC];
    logic [SYN_W-1:0]  c_colb [NC];
    logic [SYN_W-1:0]  c_res  [NC];
    logic [COST_W-1:0] c_cost [NC];

    logic [COST_W-1:0] pk_cost;
    logic [IDX_W-1:0]  pk_a, pk_b;
    logic              pk_av, pk_bv;
    logic [SYN_W-1:0]  pk_res;

    assign last_cyc = (int'(cyc_q) == NCYC - 1);

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // ---------------- next state ----------------
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_n = ST_SEARCH;
            ST_SEARCH: if (last_cyc) state_n = ST_DONE;
            ST_DONE:                 state_n = ST_IDLE;
            default:                 state_n = ST_IDLE;
        endcase
    end

    // ---------------- outputs ----------------
    always_comb begin
        busy = (state_q == ST_SEARCH);
        done = (state_q == ST_DONE);
    end

    // ---------------- candidate generation ----------------
    fs_pair_gen #(.N_FAIR(N_FAIR), .PPC(PPC), .IDX_W(IDX_W)) u_pairs (
        .cur_i (pi_q),
        .cur_j (pj_q),
        .slot_i(slot_i),
        .slot_j(slot_j),
        .nxt_i (pi_n),
        .nxt_j (pj_n)
    );

    always_comb begin
        c_vld[0] = (int'(cyc_q) < N_REL);
        c_a[0]   = c_vld[0] ? IDX_W'(cyc_q) : '0;
        c_b[0]   = '0;
        c_bv[0]  = 1'b0;
        for (int k = 1; k < NC; k++) begin
            c_vld[k] = (int'(cyc_q) * PPC + (k - 1) < NPAIRS);
            c_a[k]   = c_vld[k] ? slot_i[k-1] : '0;
            c_b[k]   = c_vld[k] ? slot_j[k-1] : '0;
            c_bv[k]  = 1'b1;
        end
        for (int k = 0; k < NC; k++) begin
            c_cola[k] = '0;
            c_colb[k] = '0;
            for (int m = 0; m < N_REL; m++) begin
                if (c_a[k] == IDX_W'(m)) c_cola[k] = cols_q[m];
                if (c_b[k] == IDX_W'(m)) c_colb[k] = cols_q[m];
            end
        end
    end

    for (genvar g = 0; g < NC; g++) begin : g_eval
        fs_cand_eval #(.SYN_W(SYN_W), .COST_W(COST_W)) u_eval (
            .syn  (syn_q),
            .col_a(c_cola[g]),
            .col_b(c_colb[g]),
            .use_b(c_bv[g]),
            .res  (c_res[g]),
            .cost (c_cost[g])
        );
    end

    fs_best_pick #(.NC(NC), .SYN_W(SYN_W), .COST_W(COST_W), .IDX_W(IDX_W)) u_pick (
        .in_cost (best_cost),
        .in_a    (flip_a),
        .in_av   (flip_a_vld),
        .in_b    (flip_b),
        .in_bv   (flip_b_vld),
        .in_res  (resid),
        .c_vld   (c_vld),
        .c_cost  (c_cost),
        .c_a     (c_a),
        .c_b     (c_b),
        .c_bv    (c_bv),
        .c_res   (c_res),
        .out_cost(pk_cost),
        .out_a   (pk_a),
        .out_av  (pk_av),
        .out_b   (pk_b),
        .out_bv  (pk_bv),
        .out_res (pk_res)
    );

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc_q      <= '0;
            syn_q      <= '0;
            pi_q       <= '0;
            pj_q       <= '0;
            best_cost  <= '0;
            flip_a     <= '0;
            flip_a_vld <= 1'b0;
            flip_b     <= '0;
            flip_b_vld <= 1'b0;
            resid      <= '0;
            for (int m = 0; m < N_REL; m++) cols_q[m] <= '0;
        end else if (state_q == ST_IDLE && start) begin
            cyc_q      <= '0;
            syn_q      <= syn_in;
            pi_q       <= IDX_W'(0);
            pj_q       <= IDX_W'(1);
            best_cost  <= COST_W'($countones(syn_in));
            flip_a     <= '0;
            flip_a_vld <= 1'b0;
            flip_b     <= '0;
            flip_b_vld <= 1'b0;
            resid      <= syn_in;
            for (int m = 0; m < N_REL; m++) cols_q[m] <= cols_in[m*SYN_W +: SYN_W];
        end else if (state_q == ST_SEARCH) begin
            cyc_q      <= cyc_q + 1'b1;
            pi_q       <= pi_n;
            pj_q       <= pj_n;
            best_cost  <= pk_cost;
            flip_a     <= pk_a;
            flip_a_vld <= pk_av;
            flip_b     <= pk_b;
            flip_b_vld <= pk_bv;
            resid      <= pk_res;
        end
    end

endmodule

// File: rtl/fs_checker.sv
module fs_checker #(
    parameter int SYN_W  = 8,
    parameter int N_REL  = 10,
    parameter int N_FAIR = 8,
    parameter int COST_W = 4,
    parameter int IDX_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              busy,
    input logic              done,
    input logic [COST_W-1:0] best_cost,
    input logic [IDX_W-1:0]  flip_a,
    input logic              flip_a_vld,
    input logic [IDX_W-1:0]  flip_b,
    input logic              flip_b_vld,
    input logic [SYN_W-1:0]  resid
);
    assert_done_after_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_cost_monotone_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> (best_cost <= $past(best_cost)));

    assert_cost_sum_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int'(best_cost) == $countones(resid) + int'(flip_a_vld) + int'(flip_b_vld));

    assert_pair_order_R4: assert property (@(posedge clk) disable iff (!rst_n)
        flip_b_vld |-> (flip_a_vld && (flip_a < flip_b) && (int'(flip_b) < N_FAIR)));

    assert_single_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
        flip_a_vld |-> (int'(flip_a) < N_REL));

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !$past(busy) && !$past(start)) |-> ($stable(best_cost) && $stable(resid)
            && $stable(flip_a_vld) && $stable(flip_b_vld)));

endmodule

bind flip_search_unit fs_checker #(
    .SYN_W (SYN_W),
    .N_REL (N_REL),
    .N_FAIR(N_FAIR),
    .COST_W(COST_W),
    .IDX_W (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .done      (done),
    .best_cost (best_cost),
    .flip_a    (flip_a),
    .flip_a_vld(flip_a_vld),
    .flip_b    (flip_b),
    .flip_b_vld(flip_b_vld),
    .resid     (resid)
);

// File: tb/flip_search_unit_tb.sv
module flip_search_unit_tb;
    localparam int SYN_W  = 8;
    localparam int N_REL  = 10;
    localparam int N_FAIR = 8;
    localparam int PPC    = 6;
    localparam int COST_W = $clog2(SYN_W + 3);
    localparam int IDX_W  = $clog2(N_REL + 2);
    localparam int NP     = N_FAIR * (N_FAIR - 1) / 2;
    localparam int PCYC   = (NP + PPC - 1) / PPC;
    localparam int NCYC   = (N_REL > PCYC) ? N_REL : PCYC;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   start = 1'b0;
    logic [SYN_W-1:0]       syn_in = '0;
    logic [N_REL*SYN_W-1:0] cols_in = '0;
    logic                   busy, done;
    logic [COST_W-1:0]      best_cost;
    logic [IDX_W-1:0]       flip_a, flip_b;
    logic                   flip_a_vld, flip_b_vld;
    logic [SYN_W-1:0]       resid;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [SYN_W-1:0] cols [N_REL];
    int pq_i [$];
    int pq_j [$];
    int e_cost, e_a, e_av, e_b, e_bv, e_res;

    always #5 clk = ~clk;

    flip_search_unit #(.SYN_W(SYN_W), .N_REL(N_REL), .N_FAIR(N_FAIR), .PPC(PPC)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .syn_in(syn_in), .cols_in(cols_in),
        .busy(busy), .done(done), .best_cost(best_cost),
        .flip_a(flip_a), .flip_a_vld(flip_a_vld), .flip_b(flip_b), .flip_b_vld(flip_b_vld),
        .resid(resid)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int wt(input logic [SYN_W-1:0] v);
        int n = 0;
        for (int b = 0; b < SYN_W; b++) n += int'(v[b]);
        return n;
    endfunction

    // reference: candidates in required order, strict improvement
    task automatic model(input logic [SYN_W-1:0] s);
        logic [SYN_W-1:0] r;
        int c;
        e_cost = wt(s); e_a = 0; e_av = 0; e_b = 0; e_bv = 0; e_res = int'(s);
        for (int cy = 0; cy < NCYC; cy++) begin
            if (cy < N_REL) begin
                r = s ^ cols[cy];
                c = 1 + wt(r);
                if (c < e_cost) begin
                    e_cost = c; e_a = cy; e_av = 1; e_b = 0; e_bv = 0; e_res = int'(r);
                end
            end
            for (int k = 0; k < PPC; k++) begin
                int lin;
                lin = cy * PPC + k;
                if (lin < NP) begin
                    r = s ^ cols[pq_i[lin]] ^ cols[pq_j[lin]];
                    c = 2 + wt(r);
                    if (c < e_cost) begin
                        e_cost = c; e_a = pq_i[lin]; e_av = 1; e_b = pq_j[lin]; e_bv = 1;
                        e_res = int'(r);
                    end
                end
            end
        end
    endtask

    task automatic check_result(input string req);
        chk(int'(best_cost) == e_cost, req, "best_cost", int'(best_cost), e_cost);
        chk(int'(flip_a_vld) == e_av, req, "flip_a_vld", int'(flip_a_vld), e_av);
        chk(int'(flip_b_vld) == e_bv, req, "flip_b_vld", int'(flip_b_vld), e_bv);
        if (e_av != 0) chk(int'(flip_a) == e_a, req, "flip_a", int'(flip_a), e_a);
        if (e_bv != 0) chk(int'(flip_b) == e_b, req, "flip_b", int'(flip_b), e_b);
        chk(int'(resid) == e_res, req, "resid", int'(resid), e_res);
    endtask

    // drives one job; compares busy/done on every clock against the timeline
    task automatic run_job(input logic [SYN_W-1:0] s, input string req, input bit inject);
        model(s);
        @(negedge clk);
        start = 1'b1;
        syn_in = s;
        for (int m = 0; m < N_REL; m++) cols_in[m*SYN_W +: SYN_W] = cols[m];
        chk(busy == 1'b0, "R2", "busy before start", int'(busy), 0);
        @(negedge clk);
        start = 1'b0;
        for (int st = 1; st <= NCYC + 2; st++) begin
            chk(int'(busy) == int'(st <= NCYC), "R6", "busy timeline", int'(busy), int'(st <= NCYC));
            chk(int'(done) == int'(st == NCYC + 1), "R6", "done timeline", int'(done),
                int'(st == NCYC + 1));
            if (st == 1 && !inject)
                chk(int'(best_cost) <= wt(s), "R2", "initial cost bound", int'(best_cost), wt(s));
            if (st == NCYC + 1) check_result(req);
            if (st == NCYC + 2) check_result("R9");
            if (inject && st == 2) begin
                start = 1'b1;
                syn_in = ~s;
                cols_in = ~cols_in;
            end
            if (inject && st == 3) start = 1'b0;
            @(negedge clk);
        end
    endtask

    function automatic logic [SYN_W-1:0] rnd();
        return SYN_W'($urandom);
    endfunction

    initial begin
        for (int i = 0; i < N_FAIR; i++)
            for (int j = i + 1; j < N_FAIR; j++) begin
                pq_i.push_back(i);
                pq_j.push_back(j);
            end

        repeat (3) @(negedge clk);
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy", int'(busy), 0);
        chk(done == 1'b0, "R1", "done", int'(done), 0);
        chk(best_cost == '0, "R1", "best_cost", int'(best_cost), 0);
        chk(flip_a_vld == 1'b0 && flip_b_vld == 1'b0, "R1", "flip valid",
            int'(flip_a_vld) + int'(flip_b_vld), 0);
        chk(resid == '0, "R1", "resid", int'(resid), 0);
        rst_n = 1'b1;

        // structured column set: one-hot columns, two heavy ones at 6 and 7, one at 9
        for (int m = 0; m < N_REL; m++) cols[m] = SYN_W'(1) << (m % SYN_W);
        cols[6] = 8'hF0;
        cols[7] = 8'h0F;
        cols[9] = 8'h3C;

        run_job(8'h00, "R2", 1'b0);                       // no-flip wins, cost 0
        run_job(8'h3C, "R3", 1'b0);                       // single at index 9 (outside fair set)
        run_job(8'hF0, "R3", 1'b0);                       // single at index 6
        run_job(8'hFF, "R7", 1'b0);                       // pair (6,7): last rank, partial cycle
        chk(e_bv == 1 && e_a == 6 && e_b == 7, "R4", "expected pair (6,7)", e_a * 10 + e_b, 67);

        // tie: columns 2 and 5 equal, earlier single kept
        cols[2] = 8'hAA;
        cols[5] = 8'hAA;
        run_job(8'hAA, "R5", 1'b0);
        chk(e_a == 2, "R5", "tie winner", e_a, 2);

        // start and inputs changed during search are ignored
        run_job(8'hFF, "R8", 1'b1);

        for (int t = 0; t < 8; t++) begin
            for (int m = 0; m < N_REL; m++) cols[m] = rnd();
            run_job(rnd(), "R4", 1'b0);
        end

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule